// File: doc/BRIEF.md
# Trap Entry Controller

This block performs the architectural state change that happens when a hart takes a trap. A trap is either a synchronous exception or an asynchronous interrupt. When the strobe `trap_valid` is high, one clock edge chooses the target privilege level. It also saves the interrupt-enable and privilege context into the status word and records the cause, the trapping pc and the trap value for that level. In the same edge it produces a redirect pc for the fetch unit and switches the current privilege.

The block holds the privilege level, the status bits and both banks of trap registers, one for supervisor and one for machine. A plain write port lets the surrounding control-register logic load these registers. A trap on the same edge has priority over that port. The delegation masks and the two vector-base registers arrive as inputs from elsewhere.

Top module: `trap_entry_unit`

## Requirements
- R1: After reset the privilege is machine (3), the status word is zero, all six cause/epc/tval outputs are zero, `redirect_valid` is low and `redirect_pc` is zero.
- R2: A trap targets supervisor level only when the current privilege is user (0) or supervisor (1), the effective cause is below DELEG_W, and that cause's bit is set in `int_deleg` for interrupts or in `exc_deleg` for exceptions. Every other trap targets machine level.
- R3: On supervisor entry, status bit 5 takes the old bit 1, bit 8 takes 1 if the old privilege was supervisor and 0 otherwise, bit 1 is cleared, and the privilege becomes 1. Bits 3, 7 and 12:11 are unchanged.
- R4: On machine entry, status bit 7 takes the old bit 3, bits 12:11 take the old privilege, bit 3 is cleared, and the privilege becomes 3. Bits 1, 5 and 8 are unchanged.
- R5: The target level's cause register gets the effective cause in its low bits, with bit XLEN-1 set for interrupts. Its epc register gets `cur_pc`. The other level's registers keep their values.
- R6: The target level's tval register gets `trap_addr` for synchronous causes 0, 1, 4, 5, 6, 7, 12, 13 and 15, and zero for every other trap.
- R7: A synchronous cause 8 becomes 8 in user mode, 9 in supervisor mode and 11 in machine mode. This remapped value is the effective cause used for delegation and recording.
- R8: `redirect_pc` is the target level's vector register with bits 1:0 cleared. For an interrupt whose vector register has bits 1:0 equal to 1, four times the effective cause is added.
- R9: `redirect_valid` is high in exactly the cycle after each edge at which `trap_valid` was high.
- R10: The write port (`wr_sel` 0 status, 1 privilege, 2..4 machine cause/epc/tval, 5..7 supervisor cause/epc/tval) has no effect on an edge where `trap_valid` is high. A privilege value of 2 is stored as 0, and so is a value of 2 written to status bits 12:11.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| trap_valid | input | 1 | Take a trap on this edge |
| trap_async | input | 1 | 1 = interrupt, 0 = exception |
| trap_cause | input | CAUSE_W | Raw cause code |
| trap_addr | input | XLEN | Faulting address |
| cur_pc | input | XLEN | Pc of the trapping instruction |
| m_tvec | input | XLEN | Machine vector base, bits 1:0 = mode |
| s_tvec | input | XLEN | Supervisor vector base, bits 1:0 = mode |
| int_deleg | input | DELEG_W | Interrupt delegation mask |
| exc_deleg | input | DELEG_W | Exception delegation mask |
| wr_en | input | 1 | Register write enable |
| wr_sel | input | 3 | Register selector |
| wr_data | input | XLEN | Write data |
| priv_o | output | 2 | Current privilege |
| status_o | output | XLEN | Status word |
| m_cause_o | output | XLEN | Machine cause |
| m_epc_o | output | XLEN | Machine epc |
| m_tval_o | output | XLEN | Machine trap value |
| s_cause_o | output | XLEN | Supervisor cause |
| s_epc_o | output | XLEN | Supervisor epc |
| s_tval_o | output | XLEN | Supervisor trap value |
| redirect_valid | output | 1 | Redirect pulse |
| redirect_pc | output | XLEN | Trap handler address |

## Verification
Every result appears one edge after the strobe, because the privilege, status, trap registers and redirect outputs are all registered at the edge where `trap_valid` is high. The bench drives each stimulus at a falling edge and samples one time unit after the following rising edge. It then checks one rising edge later that `redirect_valid` has dropped. Write-port loads follow the same one-edge rule, so every trap starts from a privilege and status word that the bench has itself loaded and mirrors.

// File: rtl/trap_entry_pkg.sv
package trap_entry_pkg;

   typedef enum logic [1:0] {
      LVL_USER = 2'd0,
      LVL_SUP  = 2'd1,
      LVL_RSVD = 2'd2,
      LVL_MACH = 2'd3
   } lvl_e;

   typedef enum logic [2:0] {
      WS_STATUS = 3'd0,
      WS_PRIV   = 3'd1,
      WS_MCAUSE = 3'd2,
      WS_MEPC   = 3'd3,
      WS_MTVAL  = 3'd4,
      WS_SCAUSE = 3'd5,
      WS_SEPC   = 3'd6,
      WS_STVAL  = 3'd7
   } wsel_e;

   // bit positions inside the status word
   localparam int BP_SIE    = 1;
   localparam int BP_MIE    = 3;
   localparam int BP_SPIE   = 5;
   localparam int BP_MPIE   = 7;
   localparam int BP_SPP    = 8;
   localparam int BP_MPP_LO = 11;

   localparam int ENV_CALL_GENERIC = 8;
   localparam int ENV_CALL_USER    = 8;
   localparam int ENV_CALL_SUP     = 9;
   localparam int ENV_CALL_MACH    = 11;

   typedef struct packed {
      logic [1:0] mpp;
      logic       spp;
      logic       mpie;
      logic       spie;
      logic       mie;
      logic       sie;
   } ctx_bits_t;

endpackage

// File: rtl/trap_route.sv
module trap_route
   import trap_entry_pkg::*;
#(
   parameter int CAUSE_W = 6,
   parameter int DELEG_W = 16
) (
   input  logic               is_async,
   input  logic [CAUSE_W-1:0] raw_cause,
   input  logic [1:0]         cur_lvl,
   input  logic [DELEG_W-1:0] irq_mask,
   input  logic [DELEG_W-1:0] exc_mask,
   output logic [CAUSE_W-1:0] eff_cause,
   output logic               to_sup
);

   logic [DELEG_W-1:0] mask_sel;
   logic [DELEG_W-1:0] mask_shift;
   logic               in_range;

   always_comb begin
      eff_cause = raw_cause;
      if (!is_async && (int'(raw_cause) == ENV_CALL_GENERIC)) begin
         case (cur_lvl)
            LVL_MACH: eff_cause = CAUSE_W'(ENV_CALL_MACH);
            LVL_SUP:  eff_cause = CAUSE_W'(ENV_CALL_SUP);
            default:  eff_cause = CAUSE_W'(ENV_CALL_USER);
         endcase
      end
   end

   assign mask_sel   = is_async ? irq_mask : exc_mask;
   assign mask_shift = mask_sel >> eff_cause;
   assign in_range   = int'(eff_cause) < DELEG_W;
   assign to_sup     = (cur_lvl != LVL_MACH) && in_range && mask_shift[0];

endmodule

// File: rtl/trap_vector.sv
module trap_vector #(
   parameter int XLEN    = 32,
   parameter int CAUSE_W = 6,
   parameter bit VEC_EN  = 1'b1
) (
   input  logic [XLEN-1:0]    tvec,
   input  logic               is_async,
   input  logic [CAUSE_W-1:0] eff_cause,
   input  logic [XLEN-1:0]    fault_addr,
   output logic [XLEN-1:0]    tgt_pc,
   output logic [XLEN-1:0]    tval
);

   logic [XLEN-1:0] base;
   logic            addr_cause;

   assign base = {tvec[XLEN-1:2], 2'b00};

   generate
      if (VEC_EN) begin : g_vectored
         logic [XLEN-1:0] offs;
         assign offs   = (is_async && tvec[1:0] == 2'b01) ? (XLEN'(eff_cause) << 2) : '0;
         assign tgt_pc = base + offs;
      end else begin : g_direct
         logic unused_mode;
         assign unused_mode = ^tvec[1:0];
         assign tgt_pc      = base;
      end
   endgenerate

   always_comb begin
      case (int'(eff_cause))
         0, 1, 4, 5, 6, 7, 12, 13, 15: addr_cause = 1'b1;
         default:                      addr_cause = 1'b0;
      endcase
   end

   assign tval = (!is_async && addr_cause) ? fault_addr : '0;

endmodule

// File: rtl/trap_entry_unit.sv
module trap_entry_unit
   import trap_entry_pkg::*;
#(
   parameter int XLEN    = 32,
   parameter int CAUSE_W = 6,
   parameter int DELEG_W = 16,
   parameter bit VEC_EN  = 1'b1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               trap_valid,
   input  logic               trap_async,
   input  logic [CAUSE_W-1:0] trap_cause,
   input  logic [XLEN-1:0]    trap_addr,
   input  logic [XLEN-1:0]    cur_pc,
   input  logic [XLEN-1:0]    m_tvec,
   input  logic [XLEN-1:0]    s_tvec,
   input  logic [DELEG_W-1:0] int_deleg,
   input  logic [DELEG_W-1:0] exc_deleg,
   input  logic               wr_en,
   input  logic [2:0]         wr_sel,
   input  logic [XLEN-1:0]    wr_data,
   output logic [1:0]         priv_o,
   output logic [XLEN-1:0]    status_o,
   output logic [XLEN-1:0]    m_cause_o,
   output logic [XLEN-1:0]    m_epc_o,
   output logic [XLEN-1:0]    m_tval_o,
   output logic [XLEN-1:0]    s_cause_o,
   output logic [XLEN-1:0]    s_epc_o,
   output logic [XLEN-1:0]    s_tval_o,
   output logic               redirect_valid,
   output logic [XLEN-1:0]    redirect_pc
);

   localparam int PAD_W = XLEN - 1 - CAUSE_W;

   generate
      if (XLEN < 16) begin : g_bad_xlen
         $error("XLEN must be at least 16");
      end
      if (PAD_W < 1) begin : g_bad_cause
         $error("CAUSE_W too wide for XLEN");
      end
      if (DELEG_W < 1 || DELEG_W > XLEN) begin : g_bad_deleg
         $error("DELEG_W out of range");
      end
   endgenerate

   lvl_e            lvl_q;
   ctx_bits_t       ctx_q;
   logic [XLEN-1:0] mcause_q, mepc_q, mtval_q;
   logic [XLEN-1:0] scause_q, sepc_q, stval_q;
   logic            rv_q;
   logic [XLEN-1:0] rpc_q;

   logic [CAUSE_W-1:0] eff_cause;
   logic               to_sup;
   logic [XLEN-1:0]    tvec_sel, tgt_pc, tval_val, cause_word;
   logic [1:0]         wr_lvl, wr_mpp;
   logic               unused_wr;

   trap_route #(.CAUSE_W(CAUSE_W), .DELEG_W(DELEG_W)) u_route (
      .is_async (trap_async),
      .raw_cause(trap_cause),
      .cur_lvl  (lvl_q),
      .irq_mask (int_deleg),
      .exc_mask (exc_deleg),
      .eff_cause(eff_cause),
      .to_sup   (to_sup)
   );

   assign tvec_sel = to_sup ? s_tvec : m_tvec;

   trap_vector #(.XLEN(XLEN), .CAUSE_W(CAUSE_W), .VEC_EN(VEC_EN)) u_vec (
      .tvec      (tvec_sel),
      .is_async  (trap_async),
      .eff_cause (eff_cause),
      .fault_addr(trap_addr),
      .tgt_pc    (tgt_pc),
      .tval      (tval_val)
   );

   assign cause_word = {trap_async, {PAD_W{1'b0}}, eff_cause};
   assign wr_lvl     = (wr_data[1:0] == 2'b10) ? 2'b00 : wr_data[1:0];
   assign wr_mpp     = (wr_data[BP_MPP_LO+1:BP_MPP_LO] == 2'b10) ? 2'b00
                                                                 : wr_data[BP_MPP_LO+1:BP_MPP_LO];
   assign unused_wr  = ^wr_data;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         lvl_q    <= LVL_MACH;
         ctx_q    <= '0;
         mcause_q <= '0;
         mepc_q   <= '0;
         mtval_q  <= '0;
         scause_q <= '0;
         sepc_q   <= '0;
         stval_q  <= '0;
         rv_q     <= 1'b0;
         rpc_q    <= '0;
      end else begin
         rv_q <= trap_valid;
         if (trap_valid) begin
            rpc_q <= tgt_pc;
            if (to_sup) begin
               ctx_q.spie <= ctx_q.sie;
               ctx_q.spp  <= (lvl_q == LVL_SUP);
               ctx_q.sie  <= 1'b0;
               lvl_q      <= LVL_SUP;
               scause_q   <= cause_word;
               sepc_q     <= cur_pc;
               stval_q    <= tval_val;
            end else begin
               ctx_q.mpie <= ctx_q.mie;
               ctx_q.mpp  <= lvl_q;
               ctx_q.mie  <= 1'b0;
               lvl_q      <= LVL_MACH;
               mcause_q   <= cause_word;
               mepc_q     <= cur_pc;
               mtval_q    <= tval_val;
            end
         end else if (wr_en) begin
            case (wsel_e'(wr_sel))
               WS_STATUS: begin
                  ctx_q.sie  <= wr_data[BP_SIE];
                  ctx_q.mie  <= wr_data[BP_MIE];
                  ctx_q.spie <= wr_data[BP_SPIE];
                  ctx_q.mpie <= wr_data[BP_MPIE];
                  ctx_q.spp  <= wr_data[BP_SPP];
                  ctx_q.mpp  <= wr_mpp;
               end
               WS_PRIV:   lvl_q    <= lvl_e'(wr_lvl);
               WS_MCAUSE: mcause_q <= wr_data;
               WS_MEPC:   mepc_q   <= wr_data;
               WS_MTVAL:  mtval_q  <= wr_data;
               WS_SCAUSE: scause_q <= wr_data;
               WS_SEPC:   sepc_q   <= wr_data;
               default:   stval_q  <= wr_data;
            endcase
         end
      end
   end

   always_comb begin
      status_o                            = '0;
      status_o[BP_SIE]                    = ctx_q.sie;
      status_o[BP_MIE]                    = ctx_q.mie;
      status_o[BP_SPIE]                   = ctx_q.spie;
      status_o[BP_MPIE]                   = ctx_q.mpie;
      status_o[BP_SPP]                    = ctx_q.spp;
      status_o[BP_MPP_LO+1:BP_MPP_LO]     = ctx_q.mpp;
   end

   assign priv_o         = lvl_q;
   assign m_cause_o      = mcause_q;
   assign m_epc_o        = mepc_q;
   assign m_tval_o       = mtval_q;
   assign s_cause_o      = scause_q;
   assign s_epc_o        = sepc_q;
   assign s_tval_o       = stval_q;
   assign redirect_valid = rv_q;
   assign redirect_pc    = rpc_q;

endmodule

// File: rtl/trap_entry_chk.sv
module trap_entry_chk #(
   parameter int XLEN = 32
) (
   input logic            clk,
   input logic            rst_n,
   input logic            trap_valid,
   input logic            trap_async,
   input logic [XLEN-1:0] cur_pc,
   input logic [1:0]      priv_o,
   input logic [XLEN-1:0] status_o,
   input logic [XLEN-1:0] m_epc_o,
   input logic [XLEN-1:0] s_epc_o,
   input logic            redirect_valid,
   input logic [XLEN-1:0] redirect_pc
);

   a_r9_pulse_follows: assert property (@(posedge clk) disable iff (!rst_n)
      trap_valid |=> redirect_valid);

   a_r9_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
      !trap_valid |=> !redirect_valid);

   a_r5_epc_saved: assert property (@(posedge clk) disable iff (!rst_n)
      trap_valid |=> (m_epc_o == $past(cur_pc) || s_epc_o == $past(cur_pc)));

   a_r3_r4_enable_cleared: assert property (@(posedge clk) disable iff (!rst_n)
      trap_valid |=> ((priv_o == 2'd3) ? !status_o[3] : !status_o[1]));

   a_r2_machine_not_delegated: assert property (@(posedge clk) disable iff (!rst_n)
      (trap_valid && priv_o == 2'd3) |=> (priv_o == 2'd3));

   a_r10_priv_legal: assert property (@(posedge clk) disable iff (!rst_n)
      priv_o != 2'd2);

   a_r8_sync_aligned: assert property (@(posedge clk) disable iff (!rst_n)
      (trap_valid && !trap_async) |=> (redirect_pc[1:0] == 2'b00));

endmodule

bind trap_entry_unit trap_entry_chk #(.XLEN(XLEN)) u_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .trap_valid    (trap_valid),
   .trap_async    (trap_async),
   .cur_pc        (cur_pc),
   .priv_o        (priv_o),
   .status_o      (status_o),
   .m_epc_o       (m_epc_o),
   .s_epc_o       (s_epc_o),
   .redirect_valid(redirect_valid),
   .redirect_pc   (redirect_pc)
);

// File: tb/trap_entry_unit_bench.sv
`timescale 1ns/1ps
module trap_entry_unit_bench;

   localparam int XLEN = 32;
   localparam int CW   = 6;
   localparam int DW   = 16;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic            trap_valid = 1'b0, trap_async = 1'b0;
   logic [CW-1:0]   trap_cause = '0;
   logic [XLEN-1:0] trap_addr = '0, cur_pc = '0, m_tvec = '0, s_tvec = '0;
   logic [DW-1:0]   int_deleg = '0, exc_deleg = '0;
   logic            wr_en = 1'b0;
   logic [2:0]      wr_sel = '0;
   logic [XLEN-1:0] wr_data = '0;
   logic [1:0]      priv_o;
   logic [XLEN-1:0] status_o, m_cause_o, m_epc_o, m_tval_o, s_cause_o, s_epc_o, s_tval_o;
   logic            redirect_valid;
   logic [XLEN-1:0] redirect_pc;

   int errors = 0;
   int checks = 0;

   // mirrored expectations
   logic [1:0]      e_priv;
   logic [XLEN-1:0] e_stat, e_mc, e_me, e_mt, e_sc, e_se, e_st;

   always #10 clk = ~clk;

   trap_entry_unit #(.XLEN(XLEN), .CAUSE_W(CW), .DELEG_W(DW)) u_trap_entry_unit (
      .clk(clk), .rst_n(rst_n), .trap_valid(trap_valid), .trap_async(trap_async),
      .trap_cause(trap_cause), .trap_addr(trap_addr), .cur_pc(cur_pc),
      .m_tvec(m_tvec), .s_tvec(s_tvec), .int_deleg(int_deleg), .exc_deleg(exc_deleg),
      .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data), .priv_o(priv_o),
      .status_o(status_o), .m_cause_o(m_cause_o), .m_epc_o(m_epc_o), .m_tval_o(m_tval_o),
      .s_cause_o(s_cause_o), .s_epc_o(s_epc_o), .s_tval_o(s_tval_o),
      .redirect_valid(redirect_valid), .redirect_pc(redirect_pc)
   );

   task automatic chk(input string tag, input logic [XLEN-1:0] act, input logic [XLEN-1:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic summary();
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   endtask

   task automatic do_write(input logic [2:0] sel, input logic [XLEN-1:0] d);
      @(negedge clk);
      wr_en = 1'b1; wr_sel = sel; wr_data = d;
      @(posedge clk); #1;
      wr_en = 1'b0;
   endtask

   task automatic check_all(input string tag);
      chk({tag, " R3/R4 priv"},  {30'd0, priv_o}, {30'd0, e_priv});
      chk({tag, " R3/R4 status"}, status_o, e_stat);
      chk({tag, " R5 mcause"},   m_cause_o, e_mc);
      chk({tag, " R5 mepc"},     m_epc_o, e_me);
      chk({tag, " R6 mtval"},    m_tval_o, e_mt);
      chk({tag, " R5 scause"},   s_cause_o, e_sc);
      chk({tag, " R5 sepc"},     s_epc_o, e_se);
      chk({tag, " R6 stval"},    s_tval_o, e_st);
   endtask

   function automatic logic [XLEN-1:0] mk_stat(input logic sie, mie, spie, mpie, spp,
                                               input logic [1:0] mpp);
      logic [XLEN-1:0] w;
      w = '0;
      w[1] = sie; w[3] = mie; w[5] = spie; w[7] = mpie; w[8] = spp; w[12:11] = mpp;
      return w;
   endfunction

   initial begin
      #(20.0 * 200000);
      errors++;
      $display("FAIL watchdog expired");
      summary();
   end

   initial begin
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      #1;
      // R1 reset state
      e_priv = 2'd3; e_stat = '0;
      e_mc = '0; e_me = '0; e_mt = '0; e_sc = '0; e_se = '0; e_st = '0;
      check_all("R1 reset");
      chk("R1 redirect_valid", {31'd0, redirect_valid}, '0);
      chk("R1 redirect_pc", redirect_pc, '0);

      // R10 reserved encodings fold to user
      do_write(3'd1, 32'd2);
      chk("R10 priv write 2", {30'd0, priv_o}, '0);
      do_write(3'd0, 32'h0000_1000);
      chk("R10 mpp write 2", status_o, '0);
      do_write(3'd0, 32'h0000_19AA);
      chk("R10 status write", status_o, 32'h0000_19AA & 32'h0000_19AA);
      e_priv = 2'd0; e_stat = 32'h0000_19AA;

      begin
         int n;
         n = 0;
         for (int pi = 0; pi < 3; pi++) begin
            for (int a = 0; a < 2; a++) begin
               for (int c = 0; c < 20; c++) begin
                  for (int md = 0; md < 3; md++) begin
                     for (int mp = 0; mp < 2; mp++) begin
                        logic [1:0]      p, ompp;
                        logic [CW-1:0]   eff;
                        logic [DW-1:0]   emask, imask, smask;
                        logic            tos, sie, mie, spie, mpie, spp;
                        logic [XLEN-1:0] mtv, stv, tv, pc, ad, cw, tvl, rpc;
                        logic            blk;
                        p = (pi == 2) ? 2'd3 : 2'(pi);
                        sie = n[0]; mie = n[1]; spie = n[2]; mpie = n[3]; spp = n[4];
                        ompp = (n % 3 == 2) ? 2'd3 : 2'(n % 3);
                        emask = (mp == 0) ? 16'h0A5A : 16'hF5A5;
                        imask = ~emask;
                        mtv = 32'h8000_0100 | 32'(md);
                        stv = 32'h0000_4200 | 32'(md);
                        pc  = 32'h1000_0000 + 32'(n * 4);
                        ad  = 32'hABC0_0000 ^ 32'(n * 7);
                        blk = n[0];

                        do_write(3'd1, {30'd0, p});
                        do_write(3'd0, mk_stat(sie, mie, spie, mpie, spp, ompp));

                        // reference expectations from requirements R2, R5..R8
                        eff = CW'(c);
                        if (a == 0 && c == 8)  // R7
                           eff = (p == 2'd0) ? CW'(8) : (p == 2'd1) ? CW'(9) : CW'(11);
                        smask = (a == 1) ? imask : emask;
                        tos = (p != 2'd3) && (eff < CW'(DW)) && smask[eff[3:0]];  // R2
                        cw  = {1'(a), 25'd0, eff};
                        tvl = (a == 0 && (eff == 0 || eff == 1 || (eff >= 4 && eff <= 7) ||
                                          eff == 12 || eff == 13 || eff == 15)) ? ad : '0;
                        tv  = tos ? stv : mtv;
                        rpc = {tv[XLEN-1:2], 2'b00} +
                              ((a == 1 && tv[1:0] == 2'b01) ? (32'(eff) << 2) : 32'd0);

                        @(negedge clk);
                        trap_valid = 1'b1; trap_async = 1'(a); trap_cause = CW'(c);
                        trap_addr = ad; cur_pc = pc; m_tvec = mtv; s_tvec = stv;
                        int_deleg = imask; exc_deleg = emask;
                        wr_en = blk; wr_sel = tos ? 3'd6 : 3'd3; wr_data = 32'hDEAD_BEEF;
                        @(posedge clk); #1;
                        trap_valid = 1'b0; wr_en = 1'b0;

                        if (tos) begin
                           e_priv = 2'd1;
                           e_stat = mk_stat(1'b0, mie, sie, mpie, (p == 2'd1), ompp);
                           e_sc = cw; e_se = pc; e_st = tvl;
                        end else begin
                           e_priv = 2'd3;
                           e_stat = mk_stat(sie, 1'b0, spie, mie, spp, p);
                           e_mc = cw; e_me = pc; e_mt = tvl;
                        end
                        check_all(blk ? "R10 blocked write/trap" : "R2 trap");
                        chk("R9 redirect_valid high", {31'd0, redirect_valid}, 32'd1);
                        chk("R8 redirect_pc", redirect_pc, rpc);
                        @(posedge clk); #1;
                        chk("R9 redirect_valid drop", {31'd0, redirect_valid}, '0);
                        n++;
                     end
                  end
               end
            end
         end
      end
      summary();
   end

endmodule